// File: doc/BRIEF.md
# Virtual Address Gate with Fault Capture

This block stands between a 32-bit core's address generation and its translation lookaside buffer. For each access it sorts the virtual address into one of several fixed regions, according to whether the core is in supervisor mode. It then produces either a physical address or a fault cause. Addresses in the supervisor-only top region pass through untranslated. User accesses to the upper half are refused. Everything else takes its frame and permissions from a TLB lookup result, which is supplied as an input.

The address check is purely combinational. When a request faults and is not a probe, three fault registers are loaded on the next clock edge:
- the faulting address register;
- a data-side flag that tells instruction-fetch faults from data faults;
- a page-table-entry address register that packs the faulting virtual page number under a software-owned table base.

A probe request reports the same fault as a plain failure and leaves every register alone. A parameter removes translation entirely, for cores built without it.

Top module: `va_fault_gate`

## Requirements
- R1: With MMU_PRESENT = 0, every valid request gives xlat_ok = 1 and paddr = vaddr, whatever the mode and TLB inputs, and no fault register ever changes.
- R2: In supervisor mode, a valid request with vaddr >= 32'hC000_0000 gives xlat_ok = 1 and paddr = vaddr, with the TLB inputs ignored. Supervisor addresses below that bound go through the TLB path.
- R3: In user mode, a valid request with vaddr >= 32'h8000_0000 faults with cause 1 (supervisor-only address). On the next edge badaddr takes vaddr, while tlb_d and pteaddr keep their values.
- R4: On the TLB path, a hit that carries the needed permission gives xlat_ok = 1 and paddr = {tlb_pfn, vaddr[11:0]}, with 4 KiB pages.
- R5: Access kind is encoded 0 = fetch, 1 = load, 2 = store, 3 = load. The needed permission is tlb_ex_ok for fetch, tlb_rd_ok for load and tlb_wr_ok for store. A hit lacking it faults with cause 5, 3 or 4 respectively.
- R6: On the TLB path, a miss faults with cause 2, whatever the permission inputs. Whenever xlat_ok is 0, paddr is 0.
- R7: After a non-probe TLB fault (cause 2 to 5), tlb_d is 0 if the access was a fetch and 1 otherwise, from the next edge on.
- R8: After a non-probe TLB fault, pteaddr[21:2] holds vaddr[31:12], pteaddr[31:22] keeps the table base, pteaddr[1:0] stays 0, and badaddr holds vaddr.
- R9: With probe = 1, a faulting request raises probe_fail instead of fault_valid and reports the same cause, and no register changes. At most one of xlat_ok, fault_valid and probe_fail is high.
- R10: Reset clears badaddr, pteaddr and tlb_d to 0.
- R11: ptbase_wr loads ptbase_data into pteaddr[31:22] on the next edge. It takes effect even in the same cycle as a TLB fault, whose VPN load proceeds alongside it.
- R12: With req_valid = 0, xlat_ok, fault_valid and probe_fail are 0, fault_cause is 0, and no fault register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| supv | input | 1 | Supervisor mode |
| probe | input | 1 | Probe: report only, touch no register |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_pfn | input | 20 | Physical frame from the TLB |
| tlb_rd_ok | input | 1 | Page readable |
| tlb_wr_ok | input | 1 | Page writable |
| tlb_ex_ok | input | 1 | Page executable |
| ptbase_wr | input | 1 | Load the table-base field |
| ptbase_data | input | 10 | New table base |
| xlat_ok | output | 1 | Access translated without fault |
| paddr | output | 32 | Physical address, 0 on fault |
| fault_valid | output | 1 | Non-probe fault, registers load at next edge |
| probe_fail | output | 1 | Probe request would fault |
| fault_cause | output | 3 | 0 none, 1 supervisor-only, 2 miss, 3 read, 4 write, 5 execute |
| badaddr | output | 32 | Last faulting address |
| pteaddr | output | 32 | Table base and faulting VPN |
| tlb_d | output | 1 | Last TLB fault was a data access |

## Verification
The bench builds two copies side by side. The first uses the default parameters: MMU_PRESENT = 1, 4 KiB pages, the VPN at bit 2 and the region bounds at 32'h8000_0000 and 32'h C000_0000. It reaches every region boundary, every permission fault type, the alternation of the data flag, and the table base kept across faults. The second sets MMU_PRESENT = 0, which makes the flat variant reachable. Both copies see the same stimulus, so user-barred addresses and TLB misses can be shown to pass through the flat copy untouched.

// File: rtl/va_gate_pkg.sv
package va_gate_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_LOAD2 = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      CZ_NONE       = 3'd0,
      CZ_SUPER_ADDR = 3'd1,
      CZ_TLB_MISS   = 3'd2,
      CZ_PERM_RD    = 3'd3,
      CZ_PERM_WR    = 3'd4,
      CZ_PERM_EX    = 3'd5
   } fault_cause_e;

   typedef enum logic [1:0] {
      RG_FLAT,
      RG_KERN_BYPASS,
      RG_USER_BARRED,
      RG_MAPPED
   } region_e;

endpackage

// File: rtl/va_region_decode.sv
module va_region_decode
   import va_gate_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                MMU_PRESENT = 1,
   parameter logic [ADDR_W-1:0] KERN_BASE   = 32'hC000_0000,
   parameter logic [ADDR_W-1:0] USER_LIMIT  = 32'h8000_0000
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              supv,
   output region_e           region
);

   if (KERN_BASE < USER_LIMIT) begin : g_bad_bounds
      $error("KERN_BASE must not lie below USER_LIMIT");
   end

   if (MMU_PRESENT == 0) begin : g_flat
      logic unused_in;
      assign unused_in = ^{vaddr, supv};
      assign region    = RG_FLAT;
   end else begin : g_mapped
      always_comb begin
         if (supv) begin
            region = (vaddr >= KERN_BASE) ? RG_KERN_BYPASS : RG_MAPPED;
         end else begin
            region = (vaddr >= USER_LIMIT) ? RG_USER_BARRED : RG_MAPPED;
         end
      end
   end

endmodule

// File: rtl/va_perm_check.sv
module va_perm_check
   import va_gate_pkg::*;
#(
   parameter  int ADDR_W    = 32,
   parameter  int PAGE_BITS = 12,
   localparam int PFN_W     = ADDR_W - PAGE_BITS
) (
   input  region_e           region,
   input  acc_kind_e         kind,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              hit,
   input  logic [PFN_W-1:0]  pfn,
   input  logic              rd_ok,
   input  logic              wr_ok,
   input  logic              ex_ok,
   output logic [ADDR_W-1:0] paddr,
   output logic              fault,
   output fault_cause_e      cause
);

   logic         need_ok;
   fault_cause_e deny_cause;

   always_comb begin
      unique case (kind)
         ACC_FETCH: begin need_ok = ex_ok; deny_cause = CZ_PERM_EX; end
         ACC_STORE: begin need_ok = wr_ok; deny_cause = CZ_PERM_WR; end
         default:   begin need_ok = rd_ok; deny_cause = CZ_PERM_RD; end
      endcase
   end

   always_comb begin
      paddr = '0;
      fault = 1'b0;
      cause = CZ_NONE;
      unique case (region)
         RG_FLAT, RG_KERN_BYPASS: paddr = vaddr;
         RG_USER_BARRED: begin
            fault = 1'b1;
            cause = CZ_SUPER_ADDR;
         end
         default: begin
            if (!hit) begin
               fault = 1'b1;
               cause = CZ_TLB_MISS;
            end else if (!need_ok) begin
               fault = 1'b1;
               cause = deny_cause;
            end else begin
               paddr = {pfn, vaddr[PAGE_BITS-1:0]};
            end
         end
      endcase
   end

endmodule

// File: rtl/va_fault_regs.sv
module va_fault_regs #(
   parameter  int ADDR_W    = 32,
   parameter  int PAGE_BITS = 12,
   parameter  int VPN_LSB   = 2,
   localparam int VPN_W     = ADDR_W - PAGE_BITS,
   localparam int PTB_LSB   = VPN_LSB + VPN_W,
   localparam int PTB_W     = ADDR_W - PTB_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              capture_tlb,
   input  logic              is_fetch,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              ptbase_wr,
   input  logic [PTB_W-1:0]  ptbase_data,
   output logic [ADDR_W-1:0] badaddr,
   output logic [ADDR_W-1:0] pteaddr,
   output logic              tlb_d
);

   logic [PTB_W-1:0] ptbase_q;
   logic [VPN_W-1:0] vpn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         badaddr <= '0;
         vpn_q   <= '0;
         tlb_d   <= 1'b0;
      end else begin
         if (capture) badaddr <= vaddr;
         if (capture_tlb) begin
            vpn_q <= vaddr[ADDR_W-1:PAGE_BITS];
            tlb_d <= !is_fetch;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ptbase_q <= '0;
      else if (ptbase_wr) ptbase_q <= ptbase_data;
   end

   assign pteaddr = {ptbase_q, vpn_q, {VPN_LSB{1'b0}}};

endmodule

// File: rtl/va_fault_gate.sv
module va_fault_gate
   import va_gate_pkg::*;
#(
   parameter  int                ADDR_W      = 32,
   parameter  int                PAGE_BITS   = 12,
   parameter  int                VPN_LSB     = 2,
   parameter  int                MMU_PRESENT = 1,
   parameter  logic [ADDR_W-1:0] KERN_BASE   = 32'hC000_0000,
   parameter  logic [ADDR_W-1:0] USER_LIMIT  = 32'h8000_0000,
   localparam int                PFN_W       = ADDR_W - PAGE_BITS,
   localparam int                PTB_W       = ADDR_W - VPN_LSB - PFN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [1:0]        acc_kind,
   input  logic              supv,
   input  logic              probe,
   input  logic              tlb_hit,
   input  logic [PFN_W-1:0]  tlb_pfn,
   input  logic              tlb_rd_ok,
   input  logic              tlb_wr_ok,
   input  logic              tlb_ex_ok,
   input  logic              ptbase_wr,
   input  logic [PTB_W-1:0]  ptbase_data,
   output logic              xlat_ok,
   output logic [ADDR_W-1:0] paddr,
   output logic              fault_valid,
   output logic              probe_fail,
   output logic [2:0]        fault_cause,
   output logic [ADDR_W-1:0] badaddr,
   output logic [ADDR_W-1:0] pteaddr,
   output logic              tlb_d
);

   if (PAGE_BITS < 4 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS out of range");
   end
   if (VPN_LSB < 1 || PTB_W < 1) begin : g_bad_vpn
      $error("VPN field does not fit below the table base");
   end

   region_e           region;
   logic [ADDR_W-1:0] chk_paddr;
   logic              chk_fault;
   fault_cause_e      chk_cause;
   acc_kind_e         kind;

   assign kind = acc_kind_e'(acc_kind);

   va_region_decode #(
      .ADDR_W(ADDR_W), .MMU_PRESENT(MMU_PRESENT),
      .KERN_BASE(KERN_BASE), .USER_LIMIT(USER_LIMIT)
   ) u_region (
      .vaddr(vaddr), .supv(supv), .region(region)
   );

   va_perm_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_perm (
      .region(region), .kind(kind), .vaddr(vaddr), .hit(tlb_hit),
      .pfn(tlb_pfn), .rd_ok(tlb_rd_ok), .wr_ok(tlb_wr_ok), .ex_ok(tlb_ex_ok),
      .paddr(chk_paddr), .fault(chk_fault), .cause(chk_cause)
   );

   assign xlat_ok     = req_valid && !chk_fault;
   assign paddr       = xlat_ok ? chk_paddr : '0;
   assign fault_valid = req_valid && chk_fault && !probe;
   assign probe_fail  = req_valid && chk_fault && probe;
   assign fault_cause = req_valid ? chk_cause : CZ_NONE;

   va_fault_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .VPN_LSB(VPN_LSB)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .capture(fault_valid),
      .capture_tlb(fault_valid && chk_cause != CZ_SUPER_ADDR),
      .is_fetch(kind == ACC_FETCH),
      .vaddr(vaddr), .ptbase_wr(ptbase_wr), .ptbase_data(ptbase_data),
      .badaddr(badaddr), .pteaddr(pteaddr), .tlb_d(tlb_d)
   );

endmodule

// File: rtl/va_fault_gate_chk.sv
module va_fault_gate_chk #(
   parameter  int                ADDR_W      = 32,
   parameter  int                PAGE_BITS   = 12,
   parameter  int                VPN_LSB     = 2,
   parameter  int                MMU_PRESENT = 1,
   parameter  logic [ADDR_W-1:0] KERN_BASE   = 32'hC000_0000,
   parameter  logic [ADDR_W-1:0] USER_LIMIT  = 32'h8000_0000,
   localparam int                PTB_LSB     = VPN_LSB + ADDR_W - PAGE_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] vaddr,
   input logic [1:0]        acc_kind,
   input logic              supv,
   input logic              ptbase_wr,
   input logic              xlat_ok,
   input logic [ADDR_W-1:0] paddr,
   input logic              fault_valid,
   input logic              probe_fail,
   input logic [2:0]        fault_cause,
   input logic [ADDR_W-1:0] badaddr,
   input logic [ADDR_W-1:0] pteaddr,
   input logic              tlb_d
);

   AST_FLAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && MMU_PRESENT == 0) |-> (xlat_ok && paddr == vaddr)); // R1

   AST_KERN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && MMU_PRESENT != 0 && supv && vaddr >= KERN_BASE)
      |-> (xlat_ok && paddr == vaddr)); // R2

   AST_USER_BARRED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && MMU_PRESENT != 0 && !supv && vaddr >= USER_LIMIT)
      |-> ((fault_valid || probe_fail) && fault_cause == 3'd1)); // R3

   AST_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && fault_cause != 3'd1) |=> (tlb_d == ($past(acc_kind) != 2'd0))); // R7

   AST_BAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> (badaddr == $past(vaddr))); // R8

   AST_VPN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && fault_cause != 3'd1)
      |=> (pteaddr[PTB_LSB-1:VPN_LSB] == $past(vaddr[ADDR_W-1:PAGE_BITS]))); // R8

   AST_BASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ptbase_wr |=> $stable(pteaddr[ADDR_W-1:PTB_LSB])); // R8

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_valid |=> ($stable(badaddr) && $stable(tlb_d) && $stable(pteaddr[PTB_LSB-1:0]))); // R9

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xlat_ok, fault_valid, probe_fail})); // R9

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!xlat_ok && !fault_valid && !probe_fail && fault_cause == 3'd0)); // R12

endmodule

bind va_fault_gate va_fault_gate_chk #(
   .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .VPN_LSB(VPN_LSB),
   .MMU_PRESENT(MMU_PRESENT), .KERN_BASE(KERN_BASE), .USER_LIMIT(USER_LIMIT)
) u_chk (.*);

// File: tb/va_fault_gate_bench.sv
module va_fault_gate_bench;

   typedef struct packed {
      logic        s;
      logic        p;
      logic [1:0]  k;
      logic [31:0] va;
      logic        h;
      logic [19:0] pfn;
      logic [2:0]  rwx;
      logic        eok;
      logic        eflt;
      logic        eprb;
      logic [2:0]  ecz;
      logic [31:0] epa;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,2'd1,32'h0001_2345,1'b1,20'h0ABCD,3'b100,1'b1,1'b0,1'b0,3'd0,32'h0ABC_D345}, // R4
      '{1'b0,1'b0,2'd0,32'h0040_0FFC,1'b1,20'h12345,3'b001,1'b1,1'b0,1'b0,3'd0,32'h1234_5FFC}, // R4
      '{1'b0,1'b0,2'd2,32'h7FFF_F008,1'b1,20'h00001,3'b010,1'b1,1'b0,1'b0,3'd0,32'h0000_1008}, // R4
      '{1'b1,1'b0,2'd1,32'hC000_1234,1'b0,20'h00000,3'b000,1'b1,1'b0,1'b0,3'd0,32'hC000_1234}, // R2
      '{1'b1,1'b0,2'd0,32'hFFFF_FFFF,1'b0,20'h11111,3'b000,1'b1,1'b0,1'b0,3'd0,32'hFFFF_FFFF}, // R2
      '{1'b1,1'b0,2'd1,32'h8000_0000,1'b0,20'h00000,3'b111,1'b0,1'b1,1'b0,3'd2,32'h0},          // R2 R6
      '{1'b0,1'b0,2'd1,32'h8000_0000,1'b1,20'h00000,3'b111,1'b0,1'b1,1'b0,3'd1,32'h0},          // R3
      '{1'b0,1'b0,2'd0,32'hC000_0010,1'b1,20'h00000,3'b111,1'b0,1'b1,1'b0,3'd1,32'h0},          // R3
      '{1'b0,1'b0,2'd1,32'h1000_0004,1'b1,20'h00042,3'b011,1'b0,1'b1,1'b0,3'd3,32'h0},          // R5
      '{1'b0,1'b0,2'd2,32'h2345_6788,1'b1,20'h00042,3'b101,1'b0,1'b1,1'b0,3'd4,32'h0},          // R5
      '{1'b1,1'b0,2'd0,32'h0000_3000,1'b1,20'h00042,3'b110,1'b0,1'b1,1'b0,3'd5,32'h0},          // R5 R7
      '{1'b0,1'b0,2'd2,32'h7FFF_FFFF,1'b0,20'h00000,3'b111,1'b0,1'b1,1'b0,3'd2,32'h0},          // R6 R7
      '{1'b0,1'b0,2'd0,32'h0000_1000,1'b0,20'h00000,3'b111,1'b0,1'b1,1'b0,3'd2,32'h0},          // R6 R7
      '{1'b0,1'b1,2'd1,32'h5555_5555,1'b0,20'h00000,3'b000,1'b0,1'b0,1'b1,3'd2,32'h0},          // R9
      '{1'b0,1'b1,2'd2,32'h9000_0000,1'b1,20'h00000,3'b111,1'b0,1'b0,1'b1,3'd1,32'h0},          // R9
      '{1'b0,1'b0,2'd3,32'h0000_0ABC,1'b1,20'hFFFFF,3'b100,1'b1,1'b0,1'b0,3'd0,32'hFFFF_FABC}  // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] vaddr = '0;
   logic [1:0]  acc_kind = '0;
   logic        supv = 1'b0;
   logic        probe = 1'b0;
   logic        tlb_hit = 1'b0;
   logic [19:0] tlb_pfn = '0;
   logic        tlb_rd_ok = 1'b0;
   logic        tlb_wr_ok = 1'b0;
   logic        tlb_ex_ok = 1'b0;
   logic        ptbase_wr = 1'b0;
   logic [9:0]  ptbase_data = '0;

   logic        xlat_ok, fault_valid, probe_fail, tlb_d;
   logic [31:0] paddr, badaddr, pteaddr;
   logic [2:0]  fault_cause;
   logic        f_xlat_ok, f_fault_valid, f_probe_fail, f_tlb_d;
   logic [31:0] f_paddr, f_badaddr, f_pteaddr;
   logic [2:0]  f_fault_cause;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] m_bad = '0;
   logic [31:0] m_pte = '0;
   logic        m_d = 1'b0;

   always #2 clk = ~clk;

   va_fault_gate u_va_fault_gate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
      .acc_kind(acc_kind), .supv(supv), .probe(probe), .tlb_hit(tlb_hit),
      .tlb_pfn(tlb_pfn), .tlb_rd_ok(tlb_rd_ok), .tlb_wr_ok(tlb_wr_ok),
      .tlb_ex_ok(tlb_ex_ok), .ptbase_wr(ptbase_wr), .ptbase_data(ptbase_data),
      .xlat_ok(xlat_ok), .paddr(paddr), .fault_valid(fault_valid),
      .probe_fail(probe_fail), .fault_cause(fault_cause), .badaddr(badaddr),
      .pteaddr(pteaddr), .tlb_d(tlb_d)
   );

   va_fault_gate #(.MMU_PRESENT(0)) u_va_fault_gate_flat (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
      .acc_kind(acc_kind), .supv(supv), .probe(probe), .tlb_hit(tlb_hit),
      .tlb_pfn(tlb_pfn), .tlb_rd_ok(tlb_rd_ok), .tlb_wr_ok(tlb_wr_ok),
      .tlb_ex_ok(tlb_ex_ok), .ptbase_wr(1'b0), .ptbase_data(ptbase_data),
      .xlat_ok(f_xlat_ok), .paddr(f_paddr), .fault_valid(f_fault_valid),
      .probe_fail(f_probe_fail), .fault_cause(f_fault_cause), .badaddr(f_badaddr),
      .pteaddr(f_pteaddr), .tlb_d(f_tlb_d)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic chk_regs(input string rq);
      chk({rq, " badaddr"}, badaddr, m_bad);
      chk({rq, " pteaddr"}, pteaddr, m_pte);
      chk({rq, " tlb_d"}, {31'b0, tlb_d}, {31'b0, m_d});
   endtask

   task automatic drive(input vec_t v);
      req_valid = 1'b1;
      supv      = v.s;
      probe     = v.p;
      acc_kind  = v.k;
      vaddr     = v.va;
      tlb_hit   = v.h;
      tlb_pfn   = v.pfn;
      {tlb_rd_ok, tlb_wr_ok, tlb_ex_ok} = v.rwx;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset", {badaddr[31:1], tlb_d}, 32'h0);
      chk("R10 reset pteaddr", pteaddr, 32'h0);
      chk("R12 idle outputs", {28'b0, xlat_ok, fault_valid, probe_fail, |fault_cause}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // table base load
      @(negedge clk);
      ptbase_wr = 1'b1;
      ptbase_data = 10'h2A5;
      @(posedge clk);
      #1;
      ptbase_wr = 1'b0;
      m_pte = {10'h2A5, 22'h0};
      chk("R11 base load", pteaddr, m_pte);

      // vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         #1;
         chk($sformatf("R4 R5 vec%0d ok", i), {31'b0, xlat_ok}, {31'b0, VECS[i].eok});
         chk($sformatf("R3 R6 vec%0d fault", i), {31'b0, fault_valid}, {31'b0, VECS[i].eflt});
         chk($sformatf("R9 vec%0d probe", i), {31'b0, probe_fail}, {31'b0, VECS[i].eprb});
         chk($sformatf("R5 R6 vec%0d cause", i), {29'b0, fault_cause}, {29'b0, VECS[i].ecz});
         chk($sformatf("R2 R4 vec%0d paddr", i), paddr, VECS[i].epa);
         chk($sformatf("R1 vec%0d flat", i), f_paddr, VECS[i].va);
         chk($sformatf("R1 vec%0d flat ok", i), {31'b0, f_xlat_ok}, 32'h1);
         if (VECS[i].eflt) begin
            m_bad = VECS[i].va;
            if (VECS[i].ecz != 3'd1) begin
               m_pte = {m_pte[31:22], VECS[i].va[31:12], 2'b00};
               m_d   = (VECS[i].k != 2'd0);
            end
         end
         @(posedge clk);
         #1;
         chk_regs($sformatf("R3 R7 R8 R9 vec%0d", i));
         chk($sformatf("R1 vec%0d flat regs", i), f_badaddr | f_pteaddr, 32'h0);
         req_valid = 1'b0;
      end

      // idle request with faulting inputs
      @(negedge clk);
      req_valid = 1'b0;
      supv = 1'b0; probe = 1'b0; vaddr = 32'hABCD_0000; acc_kind = 2'd0; tlb_hit = 1'b0;
      #1;
      chk("R12 idle no outcome", {28'b0, xlat_ok, fault_valid, probe_fail, |fault_cause}, 32'h0);
      @(posedge clk);
      #1;
      chk_regs("R12 idle");

      // base write in the same cycle as a miss
      @(negedge clk);
      drive('{1'b0,1'b0,2'd1,32'h0123_4567,1'b0,20'h0,3'b000,1'b0,1'b1,1'b0,3'd2,32'h0});
      ptbase_wr = 1'b1;
      ptbase_data = 10'h15A;
      @(posedge clk);
      #1;
      ptbase_wr = 1'b0;
      req_valid = 1'b0;
      m_bad = 32'h0123_4567;
      m_pte = {10'h15A, 20'h01234, 2'b00};
      m_d   = 1'b1;
      chk_regs("R11 R8 base with fault");

      // reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      m_bad = '0; m_pte = '0; m_d = 1'b0;
      chk_regs("R10 mid reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule